// File: doc/BRIEF.md
# Descriptor Retirement Tracker

This block follows the consumption point of a descriptor ring that a transmit engine walks through. The engine publishes how far it has read (its head index). The tracker chases that index with its own software head, one descriptor per clock, and counts every descriptor it retires. Alongside it keeps a short ordered queue of outstanding packet requests. Each request owns a span of ring slots, given by a first index and a stop index. When the software head lands on the stop index of the oldest request, that request completes with an OK status.

Requests are pushed with a tag, the number of descriptors they post, and the number of leading descriptors that do not belong to the request (for example a header slot). The tracker advances its tail and generation from these values and computes the owned span itself. Retired descriptors outside the oldest request's span are stepped over and raise no completion. An abort strobe halts retirement and flushes every queued request, oldest first, one per cycle with an ABORTED status. It then brings the counters back into step: the removed count is set equal to the added count, and head, tail and generation return to zero. A request pushed while the engine is stopped is queued with empty indices and flushed through the same path, so completion order is kept.

Top module: `desc_retire_tracker`

## Requirements
- R1: After reset the software head, tail and generation are 0. No completion or retirement is flagged, the free count is RING_SIZE-1 and push_ready is 1.
- R2: While running is 1, no flush is in progress and sw_head differs from hw_head, the block retires one descriptor in each cycle. sw_head then increases by one and wraps from RING_SIZE-1 to 0, ret_valid pulses, and the removed count goes up by one.
- R3: When the head index after an advance equals the stop index of the oldest queued request, cpl_valid pulses with that request's tag and status OK (cpl_status 0), and the next request becomes the oldest. At most one completion appears per cycle.
- R4: A retired descriptor is flagged as owned (ret_owned 1) only when its index lies in the oldest request's span: the first index up to but not including the stop index, taken modulo RING_SIZE. Lead descriptors and descriptors with no queued request retire with ret_owned 0 and raise no completion.
- R5: An accepted push while running sets first = tail + push_lead and stop = tail + push_ndesc, both modulo RING_SIZE. The tail moves to stop and the added count grows by push_ndesc. The 2-bit generation increments whenever the tail wraps.
- R6: free_cnt equals RING_SIZE-1 minus (added count minus removed count), evaluated in CNT_W-bit modular arithmetic.
- R7: An abort flushes every queued request, oldest first, one per cycle, with cpl_status 1 (ABORTED). In the cycle after the queue is empty the removed count takes the added count's value, and head, tail and generation become 0.
- R8: The removed count never decreases. Resynchronisation only moves it forward to the added count, so free_cnt reads RING_SIZE-1 right after it.
- R9: A push accepted while running is 0 is queued with zero indices and changes neither the tail nor the added count. It starts a flush that completes the queued requests in order with status ABORTED and does not resynchronise the counters.
- R10: The request queue holds QUEUE_DEPTH (8) entries. push_ready is 0 when the queue is full or a flush is in progress, and a push offered while push_ready is 0 changes no state.
- R11: No descriptor retires while running is 0 or while a flush is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| running | input | 1 | Engine is running |
| hw_head | input | IDX_W | Engine read index |
| push_valid | input | 1 | Request push strobe |
| push_tag | input | TAG_W | Tag of the pushed request |
| push_ndesc | input | IDX_W | Descriptors posted by the push (1..RING_SIZE-1) |
| push_lead | input | IDX_W | Leading descriptors not owned by the request (< push_ndesc) |
| abort | input | 1 | Flush all requests and resynchronise |
| push_ready | output | 1 | Push will be accepted this cycle |
| cpl_valid | output | 1 | Completion pulse |
| cpl_tag | output | TAG_W | Tag of the completed request |
| cpl_status | output | 1 | 0 = OK, 1 = ABORTED |
| ret_valid | output | 1 | A descriptor retired in the last cycle |
| ret_owned | output | 1 | The retired descriptor lay in the oldest request's span |
| sw_head | output | IDX_W | Software head index |
| sw_tail | output | IDX_W | Software tail index |
| gen | output | 2 | Tail generation |
| free_cnt | output | CNT_W | Free ring slots |

## Verification
If the head counter goes wrong, the next retirement shows it on sw_head. A completion then appears one or more cycles early or late against the stop index, and free_cnt drifts at the same clock edge. If a queue entry is lost or reordered, a cpl_tag mismatch shows at the next completion. A missed resynchronisation after a flush shows in the following cycle as a nonzero head or tail, or as free_cnt below RING_SIZE-1. Random pushes, head movement, stopped-engine pushes and aborts are mixed with directed runs: a lead-slot request, a full queue, tail wraps that step the generation, and aborts with several requests queued.

// File: rtl/desc_trk_pkg.sv
package desc_trk_pkg;
    typedef enum logic {
        CPL_OK      = 1'b0,
        CPL_ABORTED = 1'b1
    } cpl_status_e;

    localparam int GEN_W = 2;
endpackage

// File: rtl/desc_req_fifo.sv
module desc_req_fifo #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [OCC_W-1:0] occ;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [WIDTH-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (p_q.occ == OCC_W'(DEPTH));
    assign empty = (p_q.occ == '0);
    assign dout  = mem[p_q.rd];

    always_comb begin
        p_d = p_q;
        if (push && !full) p_d.wr = bump(p_q.wr);
        if (pop && !empty) p_d.rd = bump(p_q.rd);
        case ({push && !full, pop && !empty})
            2'b10:   p_d.occ = p_q.occ + 1'b1;
            2'b01:   p_d.occ = p_q.occ - 1'b1;
            default: p_d.occ = p_q.occ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[p_q.wr] <= din;
    end
endmodule

// File: rtl/desc_free_calc.sv
module desc_free_calc #(
    parameter int RING_SIZE = 16,
    parameter int CNT_W     = 16
) (
    input  logic [CNT_W-1:0] added,
    input  logic [CNT_W-1:0] removed,
    output logic [CNT_W-1:0] free_cnt
);
    localparam logic [CNT_W-1:0] CAPACITY = CNT_W'(RING_SIZE - 1);
    logic [CNT_W-1:0] in_flight;

    assign in_flight = added - removed;
    assign free_cnt  = CAPACITY - in_flight;
endmodule

// File: rtl/desc_retire_tracker.sv
module desc_retire_tracker
    import desc_trk_pkg::*;
#(
    parameter int RING_SIZE   = 16,
    parameter int QUEUE_DEPTH = 8,
    parameter int TAG_W       = 4,
    parameter int CNT_W       = 16,
    localparam int IDX_W      = $clog2(RING_SIZE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [IDX_W-1:0] hw_head,
    input  logic             push_valid,
    input  logic [TAG_W-1:0] push_tag,
    input  logic [IDX_W-1:0] push_ndesc,
    input  logic [IDX_W-1:0] push_lead,
    input  logic             abort,
    output logic             push_ready,
    output logic             cpl_valid,
    output logic [TAG_W-1:0] cpl_tag,
    output logic             cpl_status,
    output logic             ret_valid,
    output logic             ret_owned,
    output logic [IDX_W-1:0] sw_head,
    output logic [IDX_W-1:0] sw_tail,
    output logic [1:0]       gen,
    output logic [CNT_W-1:0] free_cnt
);
    localparam int ENTRY_W = TAG_W + 2 * IDX_W;
    localparam logic [IDX_W:0] RING_EXT = (IDX_W + 1)'(RING_SIZE);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] stop;
    } req_t;

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [GEN_W-1:0] gen;
        logic [CNT_W-1:0] added;
        logic [CNT_W-1:0] removed;
        logic             drain;
        logic             resync;
        logic             cpl_valid;
        logic [TAG_W-1:0] cpl_tag;
        cpl_status_e      cpl_status;
        logic             ret_valid;
        logic             ret_owned;
    } state_t;

    state_t s_d, s_q;
    req_t   front, entry;
    logic   q_push, q_pop, q_full, q_empty;
    logic [ENTRY_W-1:0] q_dout;

    // exported for the bound checker
    logic [CNT_W-1:0] removed_mon;
    logic             resync_mon, drain_mon;

    // {wrapped, index} of a + b modulo RING_SIZE
    function automatic logic [IDX_W:0] ring_sum(input logic [IDX_W-1:0] a,
                                                input logic [IDX_W-1:0] b);
        logic [IDX_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= RING_EXT) return {1'b1, IDX_W'(s - RING_EXT)};
        return {1'b0, s[IDX_W-1:0]};
    endfunction

    // (a - b) modulo RING_SIZE
    function automatic logic [IDX_W-1:0] ring_diff(input logic [IDX_W-1:0] a,
                                                   input logic [IDX_W-1:0] b);
        if (a >= b) return a - b;
        return IDX_W'({1'b0, a} + RING_EXT - {1'b0, b});
    endfunction

    desc_req_fifo #(.WIDTH(ENTRY_W), .DEPTH(QUEUE_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (entry),
        .pop   (q_pop),
        .dout  (q_dout),
        .full  (q_full),
        .empty (q_empty)
    );

    desc_free_calc #(.RING_SIZE(RING_SIZE), .CNT_W(CNT_W)) u_free (
        .added    (s_q.added),
        .removed  (s_q.removed),
        .free_cnt (free_cnt)
    );

    assign front      = req_t'(q_dout);
    assign push_ready = !q_full && !s_q.drain;

    always_comb begin
        logic [IDX_W:0] nxt;
        logic [IDX_W:0] t_stop;
        logic [IDX_W:0] t_first;
        s_d           = s_q;
        s_d.cpl_valid = 1'b0;
        s_d.ret_valid = 1'b0;
        s_d.ret_owned = 1'b0;
        q_pop         = 1'b0;
        q_push        = 1'b0;
        entry         = '0;
        nxt           = '0;
        t_stop        = '0;
        t_first       = '0;

        if (s_q.drain) begin
            if (!q_empty) begin
                q_pop          = 1'b1;
                s_d.cpl_valid  = 1'b1;
                s_d.cpl_tag    = front.tag;
                s_d.cpl_status = CPL_ABORTED;
            end else begin
                if (s_q.resync) begin
                    s_d.head    = '0;
                    s_d.tail    = '0;
                    s_d.gen     = '0;
                    s_d.removed = s_q.added;
                end
                s_d.drain  = 1'b0;
                s_d.resync = 1'b0;
            end
        end else if (running && (s_q.head != hw_head)) begin
            nxt           = ring_sum(s_q.head, IDX_W'(1));
            s_d.head      = nxt[IDX_W-1:0];
            s_d.removed   = s_q.removed + 1'b1;
            s_d.ret_valid = 1'b1;
            s_d.ret_owned = !q_empty &&
                (ring_diff(s_q.head, front.first) < ring_diff(front.stop, front.first));
            if (!q_empty && (nxt[IDX_W-1:0] == front.stop)) begin
                q_pop          = 1'b1;
                s_d.cpl_valid  = 1'b1;
                s_d.cpl_tag    = front.tag;
                s_d.cpl_status = CPL_OK;
            end
        end

        if (push_valid && push_ready) begin
            q_push = 1'b1;
            if (running) begin
                t_first     = ring_sum(s_q.tail, push_lead);
                t_stop      = ring_sum(s_q.tail, push_ndesc);
                entry       = '{tag: push_tag, first: t_first[IDX_W-1:0],
                                stop: t_stop[IDX_W-1:0]};
                s_d.tail    = t_stop[IDX_W-1:0];
                s_d.gen     = s_q.gen + GEN_W'(t_stop[IDX_W]);
                s_d.added   = s_q.added + CNT_W'(push_ndesc);
            end else begin
                entry     = '{tag: push_tag, first: '0, stop: '0};
                s_d.drain = 1'b1;
            end
        end

        if (abort) begin
            s_d.drain  = 1'b1;
            s_d.resync = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q            <= '0;
            s_q.cpl_status <= CPL_OK;
        end else begin
            s_q <= s_d;
        end
    end

    assign cpl_valid   = s_q.cpl_valid;
    assign cpl_tag     = s_q.cpl_tag;
    assign cpl_status  = s_q.cpl_status;
    assign ret_valid   = s_q.ret_valid;
    assign ret_owned   = s_q.ret_owned;
    assign sw_head     = s_q.head;
    assign sw_tail     = s_q.tail;
    assign gen         = s_q.gen;
    assign removed_mon = s_q.removed;
    assign resync_mon  = s_q.resync;
    assign drain_mon   = s_q.drain;
endmodule

// File: rtl/desc_retire_tracker_chk.sv
module desc_retire_tracker_chk #(
    parameter int RING_SIZE = 16,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = $clog2(RING_SIZE)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             ret_valid,
    input logic             cpl_valid,
    input logic             cpl_status,
    input logic [IDX_W-1:0] sw_head,
    input logic [IDX_W-1:0] sw_tail,
    input logic [1:0]       gen,
    input logic [CNT_W-1:0] free_cnt,
    input logic [CNT_W-1:0] removed,
    input logic             resync,
    input logic             drain,
    input logic             q_full,
    input logic             push_ready
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_SIZE - 1);
    localparam logic [CNT_W-1:0] CAP      = CNT_W'(RING_SIZE - 1);

    assert_head_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> sw_head == (($past(sw_head) == LAST_IDX) ? '0 : $past(sw_head) + 1'b1));

    assert_ok_needs_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_status) |-> ret_valid);

    assert_free_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CAP);

    assert_resync_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resync) |-> (sw_head == '0 && sw_tail == '0 && gen == '0 && free_cnt == CAP));

    assert_removed_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (removed - $past(removed)) <= CNT_W'(RING_SIZE));

    assert_full_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !push_ready);

    assert_no_retire_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ($past(running) && !$past(drain)));
endmodule

bind desc_retire_tracker desc_retire_tracker_chk #(
    .RING_SIZE (RING_SIZE),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .ret_valid  (ret_valid),
    .cpl_valid  (cpl_valid),
    .cpl_status (cpl_status),
    .sw_head    (sw_head),
    .sw_tail    (sw_tail),
    .gen        (gen),
    .free_cnt   (free_cnt),
    .removed    (removed_mon),
    .resync     (resync_mon),
    .drain      (drain_mon),
    .q_full     (q_full),
    .push_ready (push_ready)
);

// File: tb/desc_retire_tracker_test.sv
`timescale 1ns/1ps
module desc_retire_tracker_test;
    localparam int RS = 16;
    localparam int QD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic running = 1'b0;
    logic [3:0] hw_head = '0;
    logic push_valid = 1'b0;
    logic [3:0] push_tag = '0;
    logic [3:0] push_ndesc = '0;
    logic [3:0] push_lead = '0;
    logic abort = 1'b0;
    logic push_ready, cpl_valid, cpl_status, ret_valid, ret_owned;
    logic [3:0] cpl_tag, sw_head, sw_tail;
    logic [1:0] gen;
    logic [15:0] free_cnt;

    always #2.5 clk = ~clk;

    desc_retire_tracker uut (
        .clk(clk), .rst_n(rst_n), .running(running), .hw_head(hw_head),
        .push_valid(push_valid), .push_tag(push_tag), .push_ndesc(push_ndesc),
        .push_lead(push_lead), .abort(abort), .push_ready(push_ready),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
        .ret_valid(ret_valid), .ret_owned(ret_owned), .sw_head(sw_head),
        .sw_tail(sw_tail), .gen(gen), .free_cnt(free_cnt)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model
    int m_head = 0, m_tail = 0, m_gen = 0, m_cnt = 0, hw = 0;
    logic [15:0] m_added = '0, m_removed = '0;
    bit m_drain = 0, m_resync = 0;
    int q_tag[QD], q_first[QD], q_stop[QD];
    bit e_cv = 0, e_cs = 0, e_rv = 0, e_ro = 0;
    int e_ct = 0;
    bit first_chk = 1, did_resync = 0, flush_cpl = 0, halted = 0;
    int tag_ctr = 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int m_free();
        logic [15:0] f;
        f = 16'(RS - 1) - (m_added - m_removed);
        return int'(f);
    endfunction

    task automatic check_outputs();
        string rs;
        rs = first_chk ? "R1" : "";
        chk(first_chk ? rs : "R3", "cpl_valid", int'(cpl_valid), int'(e_cv));
        if (e_cv) begin
            chk("R3", "cpl_tag", int'(cpl_tag), e_ct);
            chk(flush_cpl ? "R9" : "R7", "cpl_status", int'(cpl_status), int'(e_cs));
        end
        chk(first_chk ? rs : (halted ? "R11" : "R2"), "ret_valid", int'(ret_valid), int'(e_rv));
        if (e_rv) chk("R4", "ret_owned", int'(ret_owned), int'(e_ro));
        chk(first_chk ? rs : (did_resync ? "R7" : "R2"), "sw_head", int'(sw_head), m_head);
        chk(first_chk ? rs : (did_resync ? "R7" : "R5"), "sw_tail", int'(sw_tail), m_tail);
        chk(first_chk ? rs : (did_resync ? "R7" : "R5"), "gen", int'(gen), m_gen);
        chk(first_chk ? rs : (did_resync ? "R8" : "R6"), "free_cnt", int'(free_cnt), m_free());
        chk(first_chk ? rs : "R10", "push_ready", int'(push_ready),
            int'(m_cnt < QD && !m_drain));
        first_chk = 0;
    endtask

    task automatic q_pop_front();
        for (int i = 0; i < QD - 1; i++) begin
            q_tag[i] = q_tag[i+1]; q_first[i] = q_first[i+1]; q_stop[i] = q_stop[i+1];
        end
        m_cnt--;
    endtask

    task automatic model(input bit run, input bit pv, input int tg, input int nd,
                         input int ld, input bit ab);
        bit acc, was_drain;
        int old_cnt;
        old_cnt = m_cnt;
        was_drain = m_drain;
        acc = pv && old_cnt < QD && !was_drain;
        e_cv = 0; e_rv = 0; e_ro = 0; did_resync = 0;
        halted = !run || was_drain;
        if (was_drain) begin
            if (m_cnt > 0) begin
                e_cv = 1; e_ct = q_tag[0]; e_cs = 1;
                flush_cpl = !m_resync;
                q_pop_front();
            end else begin
                if (m_resync) begin
                    m_head = 0; m_tail = 0; m_gen = 0; m_removed = m_added;
                    hw = 0; did_resync = 1;
                end
                m_drain = 0; m_resync = 0;
            end
        end else if (run && m_head != int'(hw_head)) begin
            e_rv = 1;
            e_ro = (m_cnt > 0) &&
                   (((m_head - q_first[0] + RS) % RS) < ((q_stop[0] - q_first[0] + RS) % RS));
            m_head = (m_head + 1) % RS;
            m_removed = m_removed + 16'd1;
            if (m_cnt > 0 && m_head == q_stop[0]) begin
                e_cv = 1; e_ct = q_tag[0]; e_cs = 0; flush_cpl = 0;
                q_pop_front();
            end
        end
        if (acc) begin
            q_tag[m_cnt] = tg;
            if (run) begin
                q_first[m_cnt] = (m_tail + ld) % RS;
                q_stop[m_cnt]  = (m_tail + nd) % RS;
                if (m_tail + nd >= RS) m_gen = (m_gen + 1) % 4;
                m_tail = (m_tail + nd) % RS;
                m_added = m_added + 16'(nd);
            end else begin
                q_first[m_cnt] = 0; q_stop[m_cnt] = 0;
                m_drain = 1;
            end
            m_cnt++;
        end
        if (ab) begin m_drain = 1; m_resync = 1; end
    endtask

    // one clock: check, drive, model, wait
    task automatic step(input bit run, input bit pv, input int nd, input int ld,
                        input bit ab, input bit adv);
        check_outputs();
        if (adv && !m_drain && hw != m_tail) hw = (hw + 1) % RS;
        running = run; hw_head = 4'(hw); push_valid = pv;
        push_tag = 4'(tag_ctr); push_ndesc = 4'(nd); push_lead = 4'(ld); abort = ab;
        model(run, pv, tag_ctr, nd, ld, ab);
        if (pv) tag_ctr = (tag_ctr + 1) % 16;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state is checked by the first step
        // R4/R3: request with one lead slot, retired to completion
        step(1, 1, 3, 1, 0, 0);
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 1);
        // R10: fill queue, ninth push refused
        for (int i = 0; i < QD + 1; i++) step(1, 1, 1, 0, 0, 0);
        for (int i = 0; i < 12; i++) step(1, 0, 0, 0, 0, 1);
        // R5: tail wraps step the generation
        for (int k = 0; k < 5; k++) begin
            step(1, 1, 5, 2, 0, 0);
            for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0, 1);
        end
        // R11: stopped engine with outstanding work does not retire
        step(1, 1, 4, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1);
        // R7/R8: abort with several requests queued
        step(1, 1, 2, 0, 0, 0);
        step(1, 1, 3, 1, 0, 1);
        step(1, 0, 0, 0, 1, 1);
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 1);
        // R9: push while stopped, flushed without resync
        step(1, 1, 3, 0, 0, 0);
        step(0, 1, 2, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 1);
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 1);
        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            bit run, pv, ab;
            int nd, ld, fr;
            run = ($urandom % 25) != 0;
            fr = m_free();
            pv = (($urandom % 3) == 0) && fr > 0;
            nd = pv ? 1 + int'($urandom % ((fr < 6) ? fr : 6)) : 0;
            ld = (nd > 0) ? int'($urandom % nd) : 0;
            ab = ($urandom % 180) == 0;
            step(run, pv, nd, ld, ab, ($urandom % 2) == 0);
        end
        check_outputs();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule